// File: doc/BRIEF.md
# ADC Result Capture and Flag Logic

This block takes finished conversions from a multi-channel converter core and turns them into readable registers and flags. Each completion carries a channel number and a 10-bit value. The block stores the value in that channel's data register. It also stores the value, together with the channel number, in a shared last-result register. The same completion sets the channel's end-of-conversion flag and a global data-ready flag.

The rising edge of data-ready produces a one-cycle transfer request for an attached DMA channel. A maskable interrupt follows the set flags. Software, or the DMA engine, clears the flags by reading data registers over a simple register bus.

Completions arrive on a valid/ready stream. The block never applies back-pressure: `conv_ready` is high in every cycle outside reset. A beat transfers on any clock edge where `conv_valid` and `conv_ready` are both high. The bus interface, the DMA request and the interrupt are plain signals.

Top module: `adc_result_flags`

## Requirements
- R1: A completion beat on channel c writes its value into the data register of channel c, which is read at bus address c (c = 0..7) in bits [9:0]. `conv_ready` is high whenever reset is low.
- R2: Every completion also writes the last-result register at address 8, which returns the value in bits [9:0] and the producing channel in bits [12:10].
- R3: A completion on channel c sets end-of-conversion flag c and the data-ready flag. The status register at address 9 returns the eight channel flags in bits [7:0] and data-ready in bit 8.
- R4: A bus read of channel register c clears only flag c. Data-ready and the other channel flags keep their values.
- R5: A bus read of the last-result register clears data-ready and the flag of the channel stored in that register. No other flag changes.
- R6: When a completion sets a flag in the same cycle that a read clears it, the flag ends up set.
- R7: `dma_req` is high for exactly one cycle, the cycle after the clock edge at which data-ready goes from 0 to 1. It stays low while data-ready remains set.
- R8: `irq` is high exactly when some set flag has its enable bit set in the mask register. The mask register is at address 10: bits [7:0] enable the channel flags and bit 8 enables data-ready.
- R9: After reset, all data registers, the last-result register, all flags and the mask read zero, and `irq` and `dma_req` are low.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe and reflects the state before that edge. Reads of status and mask have no side effect. Unmapped addresses read zero. Writes to any address other than the mask are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | Completion beat present |
| conv_ready | output | 1 | Block accepts a beat; high outside reset |
| conv_ch | input | 3 | Channel of the completed conversion |
| conv_data | input | 10 | Conversion value |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| dma_req | output | 1 | One-cycle transfer request |
| irq | output | 1 | Masked interrupt |

## Verification
A completion beat shows up in the flags and data registers at the clock edge that accepts it. `dma_req` and `irq` change in the cycle after that edge, because both are decoded from the flag registers. Read data arrives one edge after the strobe and holds the values from before that edge, while the clear takes effect at the same edge. The bench drives inputs on falling edges and advances its model at each rising edge. It checks read data, `dma_req` and `irq` at the following falling edge, which is the first point where all three are due.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  localparam int unsigned DEF_NCH    = 8;
  localparam int unsigned DEF_RES_W  = 10;
  localparam int unsigned DEF_DATA_W = 16;
endpackage

// File: rtl/adc_res_store.sv
module adc_res_store #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned RES_W = 10,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [CH_W-1:0]      ch,
  input  logic [RES_W-1:0]     value,
  output logic [NCH*RES_W-1:0] ch_data_flat,
  output logic [RES_W-1:0]     last_data,
  output logic [CH_W-1:0]      last_ch
);
  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic [RES_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst) slot_q <= '0;
      else if (fire && ch == CH_W'(i)) slot_q <= value;
    end
    assign ch_data_flat[i*RES_W +: RES_W] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_data <= '0;
      last_ch   <= '0;
    end else if (fire) begin
      last_data <= value;
      last_ch   <= ch;
    end
  end
endmodule

// File: rtl/adc_res_flags.sv
module adc_res_flags #(
  parameter int unsigned NCH = 8,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [CH_W-1:0] ch,
  input  logic [NCH-1:0]  rd_ch_clr,
  input  logic            rd_last_clr,
  input  logic [CH_W-1:0] last_ch,
  input  logic [NCH:0]    mask,
  output logic [NCH-1:0]  eoc,
  output logic            drdy,
  output logic            dma_req,
  output logic            irq
);
  logic drdy_prev;

  for (genvar i = 0; i < NCH; i++) begin : g_eoc
    logic set_i, clr_i;
    assign set_i = fire && (ch == CH_W'(i));
    assign clr_i = rd_ch_clr[i] || (rd_last_clr && last_ch == CH_W'(i));
    always_ff @(posedge clk) begin
      if (rst)        eoc[i] <= 1'b0;
      else if (set_i) eoc[i] <= 1'b1;
      else if (clr_i) eoc[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drdy      <= 1'b0;
      drdy_prev <= 1'b0;
    end else begin
      drdy_prev <= drdy;
      if (fire)             drdy <= 1'b1;
      else if (rd_last_clr) drdy <= 1'b0;
    end
  end

  assign dma_req = drdy & ~drdy_prev;
  assign irq     = |({drdy, eoc} & mask);
endmodule

// File: rtl/adc_res_regif.sv
module adc_res_regif #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CH_W   = $clog2(NCH),
  localparam int unsigned ADDR_W = $clog2(NCH + 3)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NCH*RES_W-1:0] ch_data_flat,
  input  logic [RES_W-1:0]     last_data,
  input  logic [CH_W-1:0]      last_ch,
  input  logic [NCH-1:0]       eoc,
  input  logic                 drdy,
  output logic [NCH:0]         mask,
  output logic [NCH-1:0]       rd_ch_clr,
  output logic                 rd_last_clr
);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(NCH);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NCH + 1);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(NCH + 2);

  logic [DATA_W-1:0] rd_mux;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign rd_ch_clr[i] = bus_rd && (bus_addr == ADDR_W'(i));
  end
  assign rd_last_clr = bus_rd && (bus_addr == A_LAST);

  always_comb begin
    rd_mux = '0;
    if (bus_addr < A_LAST)
      rd_mux[RES_W-1:0] = ch_data_flat[int'(bus_addr)*RES_W +: RES_W];
    else if (bus_addr == A_LAST)
      rd_mux[RES_W+CH_W-1:0] = {last_ch, last_data};
    else if (bus_addr == A_STAT)
      rd_mux[NCH:0] = {drdy, eoc};
    else if (bus_addr == A_MASK)
      rd_mux[NCH:0] = mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      mask      <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      if (bus_wr && bus_addr == A_MASK) mask <= bus_wdata[NCH:0];
    end
  end
endmodule

// File: rtl/adc_result_flags.sv
module adc_result_flags
  import adc_res_pkg::*;
#(
  parameter int unsigned NCH    = DEF_NCH,
  parameter int unsigned RES_W  = DEF_RES_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned CH_W   = $clog2(NCH),
  localparam int unsigned ADDR_W = $clog2(NCH + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  output logic              conv_ready,
  input  logic [CH_W-1:0]   conv_ch,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              dma_req,
  output logic              irq
);
  logic                 conv_fire;
  logic [NCH*RES_W-1:0] ch_data_flat;
  logic [RES_W-1:0]     last_data;
  logic [CH_W-1:0]      last_ch;
  logic [NCH-1:0]       eoc_q;
  logic                 drdy_q;
  logic [NCH:0]         mask_q;
  logic [NCH-1:0]       rd_ch_clr;
  logic                 rd_last_clr;

  assign conv_ready = ~rst;
  assign conv_fire  = conv_valid & conv_ready;

  adc_res_store #(.NCH(NCH), .RES_W(RES_W)) store_i (
    .clk(clk), .rst(rst), .fire(conv_fire), .ch(conv_ch), .value(conv_data),
    .ch_data_flat(ch_data_flat), .last_data(last_data), .last_ch(last_ch)
  );

  adc_res_flags #(.NCH(NCH)) flags_i (
    .clk(clk), .rst(rst), .fire(conv_fire), .ch(conv_ch),
    .rd_ch_clr(rd_ch_clr), .rd_last_clr(rd_last_clr), .last_ch(last_ch),
    .mask(mask_q), .eoc(eoc_q), .drdy(drdy_q), .dma_req(dma_req), .irq(irq)
  );

  adc_res_regif #(.NCH(NCH), .RES_W(RES_W), .DATA_W(DATA_W)) regif_i (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_data_flat(ch_data_flat),
    .last_data(last_data), .last_ch(last_ch), .eoc(eoc_q), .drdy(drdy_q),
    .mask(mask_q), .rd_ch_clr(rd_ch_clr), .rd_last_clr(rd_last_clr)
  );
endmodule

// File: rtl/adc_result_flags_chk.sv
module adc_result_flags_chk #(
  parameter int unsigned NCH = 8,
  localparam int unsigned CH_W   = $clog2(NCH),
  localparam int unsigned ADDR_W = $clog2(NCH + 3)
) (
  input logic              clk,
  input logic              rst,
  input logic              fire,
  input logic [CH_W-1:0]   ch,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NCH-1:0]    eoc,
  input logic              drdy,
  input logic              dma_req,
  input logic              irq
);
  // R3
  eoc_set_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> eoc[$past(ch)]);
  // R3
  drdy_set_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> drdy);
  // R4
  ch_read_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !fire && bus_addr < ADDR_W'(NCH)) |=> !eoc[$past(bus_addr[CH_W-1:0])]);
  // R5
  last_read_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !fire && bus_addr == ADDR_W'(NCH)) |=> !drdy);
  // R7
  dma_single_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> !dma_req);
  // R7
  dma_edge_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (drdy && !$past(drdy)));
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (drdy || eoc != '0));
endmodule

bind adc_result_flags adc_result_flags_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst(rst), .fire(conv_fire), .ch(conv_ch), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .eoc(eoc_q), .drdy(drdy_q), .dma_req(dma_req), .irq(irq)
);

// File: tb/adc_result_flags_tb.sv
module adc_result_flags_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_valid = 1'b0;
  logic        conv_ready;
  logic [2:0]  conv_ch = '0;
  logic [9:0]  conv_data = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        dma_req, irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [9:0] m_data [8];
  logic [7:0] m_eoc = '0;
  logic       m_drdy = 1'b0;
  logic [9:0] m_last = '0;
  logic [2:0] m_lch = '0;
  logic [8:0] m_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_flags dut_i (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .conv_ch(conv_ch), .conv_data(conv_data), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_req(dma_req), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int model_read(input int a);
    if (a < 8)  return int'(m_data[a]);
    if (a == 8) return int'({m_lch, m_last});
    if (a == 9) return int'({m_drdy, m_eoc});
    if (a == 10) return int'(m_mask);
    return 0;
  endfunction

  // one bus/converter cycle; entered and left at a falling edge
  task automatic step(input bit f, input int ch, input int val,
                      input bit rd, input bit wr, input int addr, input int wd,
                      input string req);
    int  exp_rd;
    bit  old_drdy;
    exp_rd   = model_read(addr);
    old_drdy = m_drdy;
    conv_valid = f; conv_ch = 3'(ch); conv_data = 10'(val);
    bus_rd = rd; bus_wr = wr; bus_addr = 4'(addr); bus_wdata = 16'(wd);
    @(posedge clk);
    if (rd && addr == 8) begin m_eoc[m_lch] = 1'b0; m_drdy = 1'b0; end
    if (rd && addr < 8) m_eoc[addr] = 1'b0;
    if (wr && addr == 10) m_mask = 9'(wd);
    if (f) begin
      m_data[ch] = 10'(val); m_last = 10'(val); m_lch = 3'(ch);
      m_eoc[ch] = 1'b1; m_drdy = 1'b1;
    end
    @(negedge clk);
    conv_valid = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
    if (rd) chk(req, int'(bus_rdata), exp_rd);
    chk("R7 dma_req", int'(dma_req), int'(m_drdy && !old_drdy));
    chk("R8 irq", int'(irq), int'(|({m_drdy, m_eoc} & m_mask)));
  endtask

  task automatic conv(input int ch, input int val);
    step(1'b1, ch, val, 1'b0, 1'b0, 0, 0, "R1");
  endtask

  task automatic rd(input int addr, input string req);
    step(1'b0, 0, 0, 1'b1, 1'b0, addr, 0, req);
  endtask

  task automatic wr(input int addr, input int wd);
    step(1'b0, 0, 0, 1'b0, 1'b1, addr, wd, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_data[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 / R1: reset state at the ports
    chk("R9 irq", int'(irq), 0);
    chk("R9 dma_req", int'(dma_req), 0);
    chk("R1 conv_ready", int'(conv_ready), 1);
    for (int a = 0; a < 16; a++) rd(a, (a > 10) ? "R10 unmapped" : "R9 reset read");

    // R8: enable all flags
    wr(10, 16'h01FF);

    // R1 R2 R3 R7: every channel, first with fresh drdy edges
    for (int c = 0; c < 8; c++) begin
      conv(c, (c * 131 + 7) % 1024);
      rd(8, "R2 last");
      rd(9, "R3 status");
      rd(8, "R5 last clears");
      rd(9, "R5 status after last read");
    end
    // R7: back-to-back completions keep drdy high, no second pulse
    for (int c = 7; c >= 0; c--) conv(c, (c * 211 + 300) % 1024);
    rd(9, "R3 status all");
    for (int c = 0; c < 8; c++) begin
      rd(c, "R1 data");
      rd(9, "R4 status after channel read");
    end

    // R5: last read clears only the producing channel
    conv(5, 10'h155);
    conv(2, 10'h2AA);
    rd(8, "R5 last");
    rd(9, "R5 status");

    // R6: set beats clear on the same flag
    conv(4, 10'h0F0);
    step(1'b1, 4, 10'h0F1, 1'b1, 1'b0, 4, 0, "R6 read ch with set");
    rd(9, "R6 status eoc4 kept");
    step(1'b1, 6, 10'h3C3, 1'b1, 1'b0, 8, 0, "R6 last read with set");
    rd(9, "R6 status drdy kept");
    rd(8, "R6 last");
    conv(1, 10'h011);

    // R10: ignored writes, side-effect-free reads
    wr(1, 16'hFFFF);
    rd(1, "R10 write ignored");
    rd(9, "R10 status");
    rd(10, "R10 mask");
    rd(9, "R10 status stable");

    // R8: exhaustive mask sweep with several flags set
    for (int m = 0; m < 512; m++) begin
      wr(10, m);
      rd(10, "R8 mask readback");
    end
    rd(8, "R8 last clear");
    for (int m = 0; m < 512; m++) wr(10, m);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule